// File: doc/BRIEF.md
# Compact 16-bit Register CPU Core

This block is a small 16-bit processor core that executes one instruction per clock. Its state is two working registers (R0, R1), a result register (RR) that takes every ALU result, a zero flag, a 10-bit program counter, a 16-word data RAM and an output register that drives a port. Instructions come from an external program store: the core presents the program counter and reads the addressed 16-bit word back in the same cycle.

Each instruction word holds a 6-bit opcode and a 10-bit operand. The operand is used as an immediate value, a data RAM address or a jump target, depending on the opcode. Add and subtract always write RR. Compare changes only the zero flag. The conditional jump tests that flag. After a halt the core freezes, and it stays frozen until reset.

Top module: `tiny16_core`

## Requirements
- R1: The opcode is instruction bits 15..10 and the operand is bits 9..0. An immediate is the operand zero-extended to 16 bits.
- R2: The asynchronous active-low reset clears the PC, R0, R1, RR, the zero flag, the output register and the halted status to zero.
- R3: Opcodes 2 and 3 load R0 and R1 from RAM. Opcodes 5, 6 and 12 store R0, R1 and RR to RAM. The RAM word is selected by operand bits 3..0, and higher operand bits are ignored.
- R4: Opcode 10 writes R0+R1 and opcode 11 writes R0-R1 into RR, modulo 2^16. Neither changes R0, R1 or the zero flag.
- R5: Opcode 13 sets the zero flag exactly when R0-R1 equals 0 and changes nothing else.
- R6: Opcode 9 loads the PC with the operand.
- R7: Opcode 14 loads the PC with the operand when the zero flag is 1, and otherwise advances the PC by one.
- R8: Opcode 4 copies the RAM word addressed by the operand to the output register. Opcodes 7 and 8 load R0 and R1 with the immediate.
- R9: Opcode 1 sets halted_o. From then on the PC, the registers, the RAM and the output stay unchanged until reset.
- R10: Opcodes 0, 15 and 16 to 63 only advance the PC by one.
- R11: A loop that adds 1 to a value, stores it, outputs it and reloads it makes the output count 2, 3, 4 and so on, one step per five instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word at address pc_o |
| pc_o | output | 10 | Program counter |
| out_o | output | 16 | Output register |
| halted_o | output | 1 | High once a halt has executed |

## Verification
Immediates with the top operand bit set tell zero-extension apart from sign-extension. Subtracting a larger value from a smaller one, and adding past 0xFFFF, exposes the modulo-2^16 behaviour. The conditional jump runs with equal and unequal operands, and also with a flag set earlier and left alone by later add and subtract. That run separates a flag written only by compare from one written by every ALU operation. Reserved and undefined opcodes placed between a load and a store show that they leave the data untouched. The counting loop checks that the instructions work together over many iterations.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;
  localparam int OP_W  = 6;
  localparam int OPR_W = 10;

  typedef enum logic [OP_W-1:0] {
    OP_RSVD = 6'd0,  OP_HALT = 6'd1,  OP_LDR0 = 6'd2,  OP_LDR1 = 6'd3,
    OP_OUT  = 6'd4,  OP_STR0 = 6'd5,  OP_STR1 = 6'd6,  OP_LIR0 = 6'd7,
    OP_LIR1 = 6'd8,  OP_JMP  = 6'd9,  OP_ADD  = 6'd10, OP_SUB  = 6'd11,
    OP_STRR = 6'd12, OP_CMP  = 6'd13, OP_JZ   = 6'd14, OP_NOP  = 6'd15
  } opcode_e;

  typedef enum logic [1:0] {WSRC_R0, WSRC_R1, WSRC_RR} wsrc_e;

  typedef struct packed {
    logic  r0_we;
    logic  r1_we;
    logic  rr_we;
    logic  zf_we;
    logic  out_we;
    logic  mem_we;
    logic  use_imm;
    logic  alu_sub;
    logic  jump;
    logic  jump_z;
    logic  halt;
    wsrc_e wsrc;
  } ctrl_t;
endpackage

// File: rtl/tiny16_decode.sv
module tiny16_decode
  import tiny16_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.wsrc = WSRC_R0;
    case (opcode_e'(opcode_i))
      OP_HALT: ctrl_o.halt = 1'b1;
      OP_LDR0: ctrl_o.r0_we = 1'b1;
      OP_LDR1: ctrl_o.r1_we = 1'b1;
      OP_OUT:  ctrl_o.out_we = 1'b1;
      OP_STR0: ctrl_o.mem_we = 1'b1;
      OP_STR1: begin ctrl_o.mem_we = 1'b1; ctrl_o.wsrc = WSRC_R1; end
      OP_STRR: begin ctrl_o.mem_we = 1'b1; ctrl_o.wsrc = WSRC_RR; end
      OP_LIR0: begin ctrl_o.r0_we = 1'b1; ctrl_o.use_imm = 1'b1; end
      OP_LIR1: begin ctrl_o.r1_we = 1'b1; ctrl_o.use_imm = 1'b1; end
      OP_JMP:  ctrl_o.jump = 1'b1;
      OP_ADD:  ctrl_o.rr_we = 1'b1;
      OP_SUB:  begin ctrl_o.rr_we = 1'b1; ctrl_o.alu_sub = 1'b1; end
      OP_CMP:  begin ctrl_o.zf_we = 1'b1; ctrl_o.alu_sub = 1'b1; end
      OP_JZ:   ctrl_o.jump_z = 1'b1;
      default: ;  // reserved, no-op and undefined codes
    endcase
  end
endmodule

// File: rtl/tiny16_alu.sv
module tiny16_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] y_o,
  output logic              zero_o
);
  always_comb begin
    y_o    = sub_i ? (a_i - b_i) : (a_i + b_i);
    zero_o = (y_o == '0);
  end
endmodule

// File: rtl/tiny16_dmem.sv
module tiny16_dmem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/tiny16_core.sv
module tiny16_core
  import tiny16_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PC_W      = 10,
  parameter int RAM_DEPTH = 16,
  localparam int AW       = $clog2(RAM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       instr_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [DATA_W-1:0] out_o,
  output logic              halted_o
);
  logic [DATA_W-1:0] r0_q, r1_q, rr_q, out_q;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic              zf_q, halted_q, active;
  logic [OP_W-1:0]   opcode;
  logic [OPR_W-1:0]  operand;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] alu_y, ram_rdata, ram_wdata, load_val, imm;
  logic              alu_zero;

  assign opcode  = instr_i[15:10];
  assign operand = instr_i[9:0];
  assign imm     = DATA_W'(operand);
  assign active  = !halted_q;

  tiny16_decode i_decode (.opcode_i(opcode), .ctrl_o(ctrl));

  tiny16_alu #(.DATA_W(DATA_W)) i_alu (
    .a_i(r0_q), .b_i(r1_q), .sub_i(ctrl.alu_sub), .y_o(alu_y), .zero_o(alu_zero)
  );

  always_comb begin
    case (ctrl.wsrc)
      WSRC_R1: ram_wdata = r1_q;
      WSRC_RR: ram_wdata = rr_q;
      default: ram_wdata = r0_q;
    endcase
  end

  tiny16_dmem #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) i_dmem (
    .clk_i  (clk_i),
    .we_i   (ctrl.mem_we && active),
    .addr_i (operand[AW-1:0]),
    .wdata_i(ram_wdata),
    .rdata_o(ram_rdata)
  );

  assign load_val = ctrl.use_imm ? imm : ram_rdata;

  always_comb begin
    if (!active || ctrl.halt)              pc_d = pc_q;
    else if (ctrl.jump || (ctrl.jump_z && zf_q)) pc_d = PC_W'(operand);
    else                                   pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      r0_q     <= '0;
      r1_q     <= '0;
      rr_q     <= '0;
      out_q    <= '0;
      zf_q     <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (active) begin
        if (ctrl.r0_we)  r0_q  <= load_val;
        if (ctrl.r1_we)  r1_q  <= load_val;
        if (ctrl.rr_we)  rr_q  <= alu_y;
        if (ctrl.zf_we)  zf_q  <= alu_zero;
        if (ctrl.out_we) out_q <= ram_rdata;
        if (ctrl.halt)   halted_q <= 1'b1;
      end
    end
  end

  assign pc_o     = pc_q;
  assign out_o    = out_q;
  assign halted_o = halted_q;
endmodule

// File: rtl/tiny16_checker.sv
module tiny16_checker #(
  parameter int DATA_W = 16,
  parameter int PC_W   = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       instr_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [DATA_W-1:0] out_o,
  input logic              halted_o,
  input logic [DATA_W-1:0] r0_i,
  input logic [DATA_W-1:0] r1_i,
  input logic [DATA_W-1:0] rr_i,
  input logic              zf_i
);
  logic [5:0] op;
  logic       is_nop;
  assign op     = instr_i[15:10];
  assign is_nop = (op == 6'd0) || (op == 6'd15) || (op >= 6'd16);

  assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  assert_halt_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> ($stable(pc_o) && $stable(out_o) && $stable(r0_i) && $stable(r1_i) && $stable(rr_i)));

  assert_halt_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && op == 6'd1) |=> (halted_o && $stable(pc_o)));

  assert_jump_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && op == 6'd9) |=> (pc_o == PC_W'($past(instr_i[9:0]))));

  assert_jz_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && op == 6'd14 && !zf_i) |=> (pc_o == PC_W'($past(pc_o) + PC_W'(1))));

  assert_alu_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && (op == 6'd10 || op == 6'd11)) |=> ($stable(r0_i) && $stable(r1_i) && $stable(zf_i)));

  assert_cmp_only_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && op == 6'd13) |=> ($stable(rr_i) && $stable(r0_i) && $stable(r1_i) && $stable(out_o)));

  assert_nop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && is_nop) |=> (pc_o == PC_W'($past(pc_o) + PC_W'(1)) && $stable(r0_i) &&
                               $stable(r1_i) && $stable(rr_i) && $stable(zf_i) && $stable(out_o)));
endmodule

bind tiny16_core tiny16_checker #(.DATA_W(DATA_W), .PC_W(PC_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i), .pc_o(pc_o), .out_o(out_o),
  .halted_o(halted_o), .r0_i(r0_q), .r1_i(r1_q), .rr_i(rr_q), .zf_i(zf_q)
);

// File: tb/test_tiny16_core.sv
module test_tiny16_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i;
  logic [9:0]  pc_o;
  logic [15:0] out_o;
  logic        halted_o;
  logic [15:0] rom [64];
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  assign instr_i = rom[pc_o[5:0]];

  tiny16_core i_tiny16_core (.*);

  function automatic logic [15:0] enc(input int op, input int opr);
    return {6'(op), 10'(opr)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 64; i++) rom[i] = enc(1, 0);
  endtask

  task automatic restart();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic run_halt(input string req);
    int k = 0;
    while (!halted_o && k < 500) begin
      @(negedge clk_i);
      k++;
    end
    if (!halted_o) chk({req, " watchdog"}, 0, 1);
  endtask

  task automatic t_reset();
    clear_rom();
    rom[0] = enc(12, 3);  // RR -> [3]
    rom[1] = enc(4, 3);
    rom[2] = enc(5, 4);   // R0 -> [4]
    rom[3] = enc(14, 9);  // flag clear: falls through
    rom[4] = enc(4, 4);
    rom[5] = enc(1, 0);
    rst_ni = 1'b0;
    step(2);
    chk("R2 pc", pc_o, 0);
    chk("R2 out", out_o, 0);
    chk("R2 halted", halted_o, 0);
    rst_ni = 1'b1;
    step(2);
    chk("R2 RR cleared", out_o, 0);
    run_halt("R2");
    chk("R2 R0 cleared", out_o, 0);
    chk("R2 flag cleared", pc_o, 5);
  endtask

  task automatic t_imm_add();
    clear_rom();
    rom[0] = enc(7, 10'h3FF);
    rom[1] = enc(8, 5);
    rom[2] = enc(10, 0);
    rom[3] = enc(12, 2);
    rom[4] = enc(4, 2);
    rom[5] = enc(5, 6);
    rom[6] = enc(4, 6);
    rom[7] = enc(1, 0);
    restart();
    step(5);
    chk("R4 add", out_o, 16'h0404);
    run_halt("R1");
    chk("R1 zero-extend, R4 R0 kept", out_o, 16'h03FF);
  endtask

  task automatic t_sub_wrap();
    clear_rom();
    rom[0] = enc(7, 3);
    rom[1] = enc(8, 5);
    rom[2] = enc(11, 0);
    rom[3] = enc(12, 0);
    rom[4] = enc(4, 0);
    rom[5] = enc(2, 0);   // R0 = 0xFFFE
    rom[6] = enc(10, 0);  // with R1 = 5 -> 0x0003
    rom[7] = enc(12, 1);
    rom[8] = enc(4, 1);
    rom[9] = enc(1, 0);
    restart();
    step(5);
    chk("R4 sub wrap", out_o, 16'hFFFE);
    run_halt("R4");
    chk("R4 add wrap", out_o, 16'h0003);
  endtask

  task automatic t_cmp_jz(input int r1v, input int exp_pc, input string req);
    clear_rom();
    rom[0] = enc(7, 7);
    rom[1] = enc(8, r1v);
    rom[2] = enc(13, 0);
    rom[3] = enc(14, 6);
    rom[4] = enc(1, 0);
    rom[5] = enc(1, 0);
    rom[6] = enc(1, 0);
    restart();
    run_halt(req);
    chk(req, pc_o, exp_pc);
  endtask

  task automatic t_cmp_keeps_rr();
    clear_rom();
    rom[0] = enc(7, 9);
    rom[1] = enc(8, 4);
    rom[2] = enc(10, 0);
    rom[3] = enc(13, 0);
    rom[4] = enc(12, 5);
    rom[5] = enc(4, 5);
    rom[6] = enc(1, 0);
    restart();
    run_halt("R5");
    chk("R5 RR untouched by compare", out_o, 13);
  endtask

  task automatic t_flag_kept();
    clear_rom();
    rom[0] = enc(7, 2);
    rom[1] = enc(8, 2);
    rom[2] = enc(13, 0);  // flag = 1
    rom[3] = enc(8, 1);
    rom[4] = enc(10, 0);
    rom[5] = enc(11, 0);  // result 1, flag must stay 1
    rom[6] = enc(14, 9);
    rom[7] = enc(1, 0);
    rom[8] = enc(1, 0);
    rom[9] = enc(1, 0);
    restart();
    run_halt("R4");
    chk("R4 flag kept, R7 taken", pc_o, 9);
  endtask

  task automatic t_jump();
    clear_rom();
    rom[0] = enc(9, 3);
    rom[1] = enc(7, 1);
    rom[2] = enc(1, 0);
    rom[3] = enc(7, 16'h2A);
    rom[4] = enc(5, 7);
    rom[5] = enc(4, 7);
    rom[6] = enc(1, 0);
    restart();
    step(1);
    chk("R6 jump pc", pc_o, 3);
    run_halt("R6");
    chk("R6 skipped code", out_o, 16'h2A);
    chk("R6 halt pc", pc_o, 6);
  endtask

  task automatic t_mem();
    clear_rom();
    rom[0] = enc(8, 10'h155);
    rom[1] = enc(6, 10'h3F1);  // upper operand bits ignored -> word 1
    rom[2] = enc(4, 1);
    rom[3] = enc(6, 15);
    rom[4] = enc(8, 0);
    rom[5] = enc(2, 15);
    rom[6] = enc(3, 1);
    rom[7] = enc(10, 0);
    rom[8] = enc(12, 8);
    rom[9] = enc(4, 8);
    rom[10] = enc(1, 0);
    restart();
    step(3);
    chk("R3 store R1, address bits 3..0", out_o, 16'h0155);
    chk("R8 out copy", out_o, 16'h0155);
    run_halt("R3");
    chk("R3 loads from RAM", out_o, 16'h02AA);
  endtask

  task automatic t_nop();
    clear_rom();
    rom[0] = enc(7, 5);
    rom[1] = enc(0, 10'h3FF);
    rom[2] = enc(15, 10'h3FF);
    rom[3] = enc(16, 1);
    rom[4] = enc(63, 10'h3FF);
    rom[5] = enc(5, 2);
    rom[6] = enc(4, 2);
    rom[7] = enc(1, 0);
    restart();
    step(5);
    chk("R10 pc after no-ops", pc_o, 5);
    chk("R10 out untouched", out_o, 0);
    run_halt("R10");
    chk("R10 R0 untouched", out_o, 5);
  endtask

  task automatic t_halt();
    clear_rom();
    rom[0] = enc(7, 10'h11);
    rom[1] = enc(5, 0);
    rom[2] = enc(4, 0);
    rom[3] = enc(1, 0);
    rom[4] = enc(7, 1);
    rom[5] = enc(5, 0);
    rom[6] = enc(4, 0);
    restart();
    step(4);
    chk("R9 halted", halted_o, 1);
    step(6);
    chk("R9 pc frozen", pc_o, 3);
    chk("R9 out frozen", out_o, 16'h11);
  endtask

  task automatic t_count();
    clear_rom();
    rom[0] = enc(7, 1);
    rom[1] = enc(8, 1);
    rom[2] = enc(10, 0);
    rom[3] = enc(12, 0);
    rom[4] = enc(4, 0);
    rom[5] = enc(2, 0);
    rom[6] = enc(9, 2);
    restart();
    step(5);
    chk("R11 first value", out_o, 2);
    for (int i = 2; i <= 8; i++) begin
      step(5);
      chk("R11 count", out_o, i + 1);
    end
    chk("R11 not halted", halted_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_imm_add();
    t_sub_wrap();
    t_cmp_jz(7, 6, "R5 equal, R7 taken");
    t_cmp_jz(8, 4, "R5 unequal, R7 fall through");
    t_cmp_keeps_rr();
    t_flag_kept();
    t_jump();
    t_mem();
    t_nop();
    t_halt();
    t_count();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule